// File: doc/BRIEF.md
# Programmable Write-Strobe Width Generator

This block drives the active-low write strobe of an asynchronous byte-wide memory. The strobe width is picked at run time from a width code. Widths are deliberately kept below the memory's guaranteed write time, so that a write lands only with some chosen probability. A processor hands over a code, an address and a data byte with a one-cycle start strobe. The block then presents the address and data, holds the strobe low for the decoded number of ticks, releases it, and signals completion. A hardware controller that harvests probabilistic writes would use it to set up a device signature, or to draw raw random bits.

The clock `clk` is the fine tick. It stands for half of a 1 ns processor period, so one tick is 0.5 ns at default settings. Counting ticks takes the place of a bank of phase-shifted pulses and a selection multiplexer. The code is read as an absolute width in ticks. The legal window spans 9 ns to 13 ns (ticks 18 to 26). A code outside that window is pulled to its nearer edge. The all-ones code is a dedicated full write of 15 ns (30 ticks). With `TICKS_PER_NS` set to 4, the same structure gives 0.25 ns steps.

Top module: `wstrobe_gen`

## Requirements
- R1: While `rst` is high, and after it falls until a start is accepted, `mem_we_n` is 1 and `busy` and `done` are 0.
- R2: A code from 18 to 26 holds `mem_we_n` low for exactly that many consecutive clock cycles.
- R3: A code below 18 holds `mem_we_n` low for 18 cycles.
- R4: A code from 27 to 30 holds `mem_we_n` low for 26 cycles.
- R5: The all-ones code (31 for a 5-bit code) holds `mem_we_n` low for 30 cycles, which is the full guaranteed write.
- R6: `mem_addr` and `mem_data` take the values on `addr_in` and `data_in` from the accepting cycle. They are valid for one cycle before `mem_we_n` falls and unchanged for at least one cycle after it rises.
- R7: A start strobe that arrives while `busy` is 1 is ignored. It produces no further pulse and no change to `mem_addr` or `mem_data`.
- R8: `done` is 1 for exactly one cycle: the first cycle in which `mem_we_n` is back high.
- R9: `busy` rises in the cycle after an accepted start and stays high for 2 cycles after `mem_we_n` rises. With `start` held high, `mem_we_n` stays high for 4 cycles between two successive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine tick clock (one width step per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a write; taken only when idle |
| width_code | input | 5 | Strobe width in ticks; all ones selects a full write |
| addr_in | input | 21 | Address to write |
| data_in | input | 8 | Byte to write |
| mem_we_n | output | 1 | Active-low write strobe to the memory |
| mem_addr | output | 21 | Registered memory address |
| mem_data | output | 8 | Registered memory data |
| busy | output | 1 | A write sequence is in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench sweeps every width code. That catches an off-by-one in the strobe counter, which would stretch or shorten every pulse by a tick. It also catches a clamp at the wrong edge, which would let a 16- or 28-tick pulse through, and a full-write code that falls into the upper clamp instead of forcing 30 ticks. A start injected in the middle of a pulse, with a different address, exposes a design that re-latches its inputs or re-arms itself while busy. Holding `start` high across two writes measures the spacing between pulses, which a design with a short recovery gap would compress.

// File: rtl/wstrobe_pkg.sv
package wstrobe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_GAP   = 2'd3
  } wstrobe_phase_e;
endpackage

// File: rtl/wstrobe_width_decode.sv
module wstrobe_width_decode #(
  parameter int W          = 5,
  parameter int MIN_TICKS  = 18,
  parameter int MAX_TICKS  = 26,
  parameter int FULL_TICKS = 30
) (
  input  logic [W-1:0] code,
  output logic [W-1:0] width
);
  localparam logic [W-1:0] MIN_C     = W'(MIN_TICKS);
  localparam logic [W-1:0] MAX_C     = W'(MAX_TICKS);
  localparam logic [W-1:0] FULL_C    = W'(FULL_TICKS);
  localparam logic [W-1:0] FULL_CODE = {W{1'b1}};

  logic [W-1:0] upper;

  always_comb begin
    if (code == FULL_CODE)  upper = FULL_C;
    else if (code > MAX_C)  upper = MAX_C;
    else                    upper = code;
  end

  generate
    if (MIN_TICKS > 0) begin : g_lo_clamp
      assign width = ((code != FULL_CODE) && (code < MIN_C)) ? MIN_C : upper;
    end else begin : g_no_lo_clamp
      assign width = upper;
    end
  endgenerate
endmodule

// File: rtl/wstrobe_tick_counter.sv
module wstrobe_tick_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/wstrobe_sequencer.sv
module wstrobe_sequencer
  import wstrobe_pkg::*;
#(
  parameter int W           = 5,
  parameter int SETUP_TICKS = 1,
  parameter int GAP_TICKS   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] width,
  input  logic         cnt_zero,
  output logic         cnt_load,
  output logic [W-1:0] cnt_val,
  output logic         accept,
  output logic         we_n,
  output logic         busy,
  output logic         done
);
  localparam logic [W-1:0] SETUP_LD = W'(SETUP_TICKS - 1);
  localparam logic [W-1:0] GAP_LD   = W'(GAP_TICKS - 1);

  wstrobe_phase_e phase;
  logic [W-1:0]   width_q;

  assign accept = (phase == PH_IDLE) && start;

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (phase)
      PH_IDLE:  if (start)    begin cnt_load = 1'b1; cnt_val = SETUP_LD; end
      PH_SETUP: if (cnt_zero) begin cnt_load = 1'b1; cnt_val = width_q - W'(1); end
      PH_LOW:   if (cnt_zero) begin cnt_load = 1'b1; cnt_val = GAP_LD; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      width_q <= '0;
      we_n    <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_SETUP;
          width_q <= width;
          busy    <= 1'b1;
        end
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_LOW;
          we_n  <= 1'b0;
        end
        PH_LOW: if (cnt_zero) begin
          phase <= PH_GAP;
          we_n  <= 1'b1;
          done  <= 1'b1;
        end
        PH_GAP: if (cnt_zero) begin
          phase <= PH_IDLE;
          busy  <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> busy); // R9
endmodule

// File: rtl/wstrobe_gen.sv
module wstrobe_gen #(
  parameter int TICKS_PER_NS = 2,
  parameter int MIN_NS       = 9,
  parameter int MAX_NS       = 13,
  parameter int FULL_NS      = 15,
  parameter int SETUP_TICKS  = 1,
  parameter int GAP_TICKS    = 2,
  parameter int ADDR_W       = 21,
  parameter int DATA_W       = 8,
  localparam int MIN_TICKS   = MIN_NS * TICKS_PER_NS,
  localparam int MAX_TICKS   = MAX_NS * TICKS_PER_NS,
  localparam int FULL_TICKS  = FULL_NS * TICKS_PER_NS,
  localparam int W           = $clog2(FULL_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [W-1:0]      width_code,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              busy,
  output logic              done
);
  localparam logic [W-1:0] MIN_C  = W'(MIN_TICKS);
  localparam logic [W-1:0] FULL_C = W'(FULL_TICKS);

  logic [W-1:0] width;
  logic         cnt_load;
  logic [W-1:0] cnt_val;
  logic         cnt_zero;
  logic         accept;

  wstrobe_width_decode #(
    .W(W), .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS), .FULL_TICKS(FULL_TICKS)
  ) u_decode (
    .code  (width_code),
    .width (width)
  );

  wstrobe_tick_counter #(.W(W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  wstrobe_sequencer #(
    .W(W), .SETUP_TICKS(SETUP_TICKS), .GAP_TICKS(GAP_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .width    (width),
    .cnt_zero (cnt_zero),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .accept   (accept),
    .we_n     (mem_we_n),
    .busy     (busy),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_data <= '0;
    end else if (accept) begin
      mem_addr <= addr_in;
      mem_data <= data_in;
    end
  end

  // run length of the current low strobe, for the width checks below
  logic [W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || mem_we_n) low_run <= '0;
    else                 low_run <= low_run + W'(1);
  end

  AST_ADDR_STABLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_data))); // R6
  AST_ADDR_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> ($stable(mem_addr) && $stable(mem_data))); // R6
  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (low_run < FULL_C)); // R5
  AST_WIDTH_FLOOR: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (low_run >= MIN_C)); // R3
  AST_DONE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(mem_we_n)); // R8
endmodule

// File: tb/wstrobe_gen_test.sv
module wstrobe_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 2;
  localparam int SETUP      = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  code = '0;
  logic [20:0] addr = '0;
  logic [7:0]  data = '0;
  logic        we_n;
  logic [20:0] maddr;
  logic [7:0]  mdata;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  wstrobe_gen uut (
    .clk(clk), .rst(rst), .start(start), .width_code(code),
    .addr_in(addr), .data_in(data), .mem_we_n(we_n),
    .mem_addr(maddr), .mem_data(mdata), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_w(input int c);
    if (c == 31) return 30;
    if (c < 18)  return 18;
    if (c > 26)  return 26;
    return c;
  endfunction

  function automatic string width_req(input int c);
    if (c == 31) return "R5";
    if (c < 18)  return "R3";
    if (c > 26)  return "R4";
    return "R2";
  endfunction

  task automatic run_write(input logic [4:0] c, input logic [20:0] a, input logic [7:0] d);
    int lo;
    int bz;
    @(negedge clk);
    start = 1'b1; code = c; addr = a; data = d;
    @(negedge clk);
    start = 1'b0; addr = a ^ 21'h15555; data = ~d;
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    check(we_n == 1'b1, "R6", "strobe high in setup", int'(we_n), 1);
    check(maddr == a, "R6", "addr before fall", int'(maddr), int'(a));
    check(mdata == d, "R6", "data before fall", int'(mdata), int'(d));
    lo = 0;
    @(negedge clk);
    while (!we_n && lo < 64) begin
      lo++;
      @(negedge clk);
    end
    check(lo == exp_w(int'(c)), width_req(int'(c)), $sformatf("width code %0d", c), lo, exp_w(int'(c)));
    check(done == 1'b1, "R8", "done at rise", int'(done), 1);
    check(maddr == a, "R6", "addr held after rise", int'(maddr), int'(a));
    bz = 0;
    while (busy && bz < 64) begin
      bz++;
      @(negedge clk);
    end
    check(bz == GAP, "R9", "busy cycles after rise", bz, GAP);
    check(done == 1'b0, "R8", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lo;
    int hi;
    int guard;
    repeat (3) @(negedge clk);
    check(we_n == 1'b1, "R1", "strobe in reset", int'(we_n), 1);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(we_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1", "idle after reset",
          int'({we_n, busy, done}), 4);

    // R2 R3 R4 R5: every code
    for (int c = 0; c < 32; c++) begin
      run_write(5'(c), 21'(c * 4099 + 7), 8'(c * 37 + 1));
    end

    // R7: start while busy is ignored
    @(negedge clk);
    start = 1'b1; code = 5'd26; addr = 21'h0ABCD; data = 8'h5A;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; code = 5'd18; addr = 21'h1F00F; data = 8'hA5;
    @(negedge clk);
    start = 1'b0;
    lo = 5;
    while (!we_n && lo < 64) begin
      lo++;
      @(negedge clk);
    end
    check(lo == 26, "R7", "width unchanged by busy start", lo, 26);
    check(maddr == 21'h0ABCD, "R7", "addr unchanged by busy start", int'(maddr), 'h0ABCD);
    check(mdata == 8'h5A, "R7", "data unchanged by busy start", int'(mdata), 'h5A);
    lo = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!we_n) lo++;
    end
    check(lo == 0, "R7", "no extra pulse", lo, 0);
    check(maddr == 21'h0ABCD, "R7", "addr kept after", int'(maddr), 'h0ABCD);

    // R9: spacing with start held high
    @(negedge clk);
    start = 1'b1; code = 5'd18; addr = 21'h00123; data = 8'h11;
    guard = 0;
    while (we_n && guard < 64) begin guard++; @(negedge clk); end
    while (!we_n && guard < 128) begin guard++; @(negedge clk); end
    hi = 0;
    while (we_n && guard < 192) begin hi++; guard++; @(negedge clk); end
    start = 1'b0;
    check(hi == GAP + SETUP + 1, "R9", "high cycles between pulses", hi, GAP + SETUP + 1);
    guard = 0;
    while (busy && guard < 64) begin guard++; @(negedge clk); end
    check(busy == 1'b0 && we_n == 1'b1, "R9", "idle after back-to-back", int'(busy), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule